// File: doc/BRIEF.md
# Chunked Expansion-RAM Copy Engine

This block is a bus-mastering byte mover that sits between a host CPU's 16-bit address space and a local expansion SRAM of up to 512 KB. Software programs a host address, an expansion address and a control byte through an eight-entry register window. Writing the control byte with its go bit set makes the engine request the host bus. Once the bus is granted, it copies one byte per clock in the selected direction for a chunk of 2^n bytes.

Chunks are kept small, from 1 to 128 bytes, so the CPU is never held off the bus for more than a bounded number of cycles. When a chunk completes, both address registers keep their advanced values and the remaining-count register returns to the chunk size. Issuing the same start again therefore continues the copy at the next byte. Host bank switching is left to software between chunks.

A fixed host address mode lets the engine stream bytes to or from a single I/O data port. In that mode every byte still makes its own host access.

Top module: `xram_mover`

## Requirements
- R1: After reset, bus_req is 0, every register reads 0, and the count window (offset 6) reads 1.
- R2: The register window at cfg_addr holds control (0), host address low and high (1, 2), and expansion address low, middle and high (3, 4, 5). Only 19 expansion address bits are stored, so the high byte reads back only bits 2:0. Offset 6 is the read-only remaining count, and offset 7 reads 0.
- R3: The control byte is laid out as follows. Bit 0 is go/busy. Bit 1 is direction: 0 copies host to expansion RAM, 1 copies expansion RAM to host. Bit 2 is host-address increment. Bits 5:3 are the chunk code n, which selects 2^n bytes.
- R4: Writing the control byte with bit 0 = 1 while idle raises bus_req and the busy bit from the next cycle. No host or SRAM access occurs until bus_gnt is high.
- R5: Each clock with bus_req and bus_gnt both high moves one byte. The source read data is written to the destination address in that same cycle.
- R6: The expansion address advances by one per byte and wraps modulo 2^19.
- R7: With bit 2 = 1 the host address advances by one per byte. With bit 2 = 0 it stays fixed, but every byte still makes one host access.
- R8: A chunk takes exactly 2^n granted cycles. In the cycle after the last byte, bus_req and the busy bit are 0.
- R9: After a chunk, the address registers hold one past the last byte, and the count reads 2^n again. A repeated start continues the copy.
- R10: Register writes made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 1 | Register window select |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| bus_req | output | 1 | Host bus request, high while busy |
| bus_gnt | input | 1 | Host bus grant |
| hst_addr | output | 16 | Host address |
| hst_en | output | 1 | Host access strobe |
| hst_we | output | 1 | Host write (fetch direction) |
| hst_wdata | output | 8 | Data written to host |
| hst_rdata | input | 8 | Host read data (same cycle) |
| xr_addr | output | 19 | Expansion SRAM address |
| xr_en | output | 1 | SRAM access strobe |
| xr_we | output | 1 | SRAM write (stash direction) |
| xr_wdata | output | 8 | Data written to SRAM |
| xr_rdata | input | 8 | SRAM read data (same cycle) |

## Verification
Transfers are tried in both directions and with both incrementing and fixed host addresses. This separates a swapped direction bit from a dead increment bit. Chunk codes 0, 1, 2, 3, 4 and 7 show whether the byte count follows 2^n exactly, including the single-byte and largest cases.

A chunk is restarted without reprogramming to show that addresses carry over while the count is restored. Another chunk starts near the top of expansion memory to show the 19-bit wrap. Holding the grant low for some cycles, with register writes poked in meanwhile, tells a premature access or an accepted busy write apart from correct waiting.

// File: rtl/xm_pkg.sv
package xm_pkg;
  typedef enum logic {ST_IDLE, ST_XFER} xm_state_e;

  localparam int WIN_W = 3;
  localparam logic [WIN_W-1:0] OFS_CTRL = 3'd0;
  localparam logic [WIN_W-1:0] OFS_HLO  = 3'd1;
  localparam logic [WIN_W-1:0] OFS_HHI  = 3'd2;
  localparam logic [WIN_W-1:0] OFS_XLO  = 3'd3;
  localparam logic [WIN_W-1:0] OFS_XMID = 3'd4;
  localparam logic [WIN_W-1:0] OFS_XHI  = 3'd5;
  localparam logic [WIN_W-1:0] OFS_CNT  = 3'd6;

  localparam int CB_GO   = 0;
  localparam int CB_DIR  = 1;
  localparam int CB_INC  = 2;
  localparam int CB_CODE = 3;
endpackage

// File: rtl/xm_regs.sv
module xm_regs
  import xm_pkg::*;
#(
  parameter int HA_W   = 16,
  parameter int XA_W   = 19,
  parameter int CODE_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sel,
  input  logic              cfg_we,
  input  logic [WIN_W-1:0]  cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              busy,
  input  logic              step,
  input  logic [CNT_W-1:0]  cnt,
  output logic              dir,
  output logic              inc,
  output logic [CODE_W-1:0] code,
  output logic [HA_W-1:0]   haddr,
  output logic [XA_W-1:0]   xaddr,
  output logic              start,
  output logic [CODE_W-1:0] start_code
);
  localparam int XHI_W = XA_W - 16;

  logic              wr;
  logic              dir_q, dir_d, inc_q, inc_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [HA_W-1:0]   haddr_q, haddr_d;
  logic [XA_W-1:0]   xaddr_q, xaddr_d;

  assign wr         = cfg_sel & cfg_we & ~busy;
  assign start      = wr && (cfg_addr == OFS_CTRL) && cfg_wdata[CB_GO];
  assign start_code = cfg_wdata[CB_CODE +: CODE_W];

  always_comb begin
    dir_d   = dir_q;
    inc_d   = inc_q;
    code_d  = code_q;
    haddr_d = haddr_q;
    xaddr_d = xaddr_q;
    if (step) begin
      haddr_d = haddr_q + HA_W'(inc_q);
      xaddr_d = xaddr_q + XA_W'(1);
    end else if (wr) begin
      case (cfg_addr)
        OFS_CTRL: begin
          dir_d  = cfg_wdata[CB_DIR];
          inc_d  = cfg_wdata[CB_INC];
          code_d = cfg_wdata[CB_CODE +: CODE_W];
        end
        OFS_HLO:  haddr_d[7:0]       = cfg_wdata;
        OFS_HHI:  haddr_d[HA_W-1:8]  = cfg_wdata[HA_W-9:0];
        OFS_XLO:  xaddr_d[7:0]       = cfg_wdata;
        OFS_XMID: xaddr_d[15:8]      = cfg_wdata;
        OFS_XHI:  xaddr_d[XA_W-1:16] = cfg_wdata[XHI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      inc_q   <= 1'b0;
      code_q  <= '0;
      haddr_q <= '0;
      xaddr_q <= '0;
    end else begin
      dir_q   <= dir_d;
      inc_q   <= inc_d;
      code_q  <= code_d;
      haddr_q <= haddr_d;
      xaddr_q <= xaddr_d;
    end
  end

  always_comb begin
    case (cfg_addr)
      OFS_CTRL: cfg_rdata = 8'({code_q, inc_q, dir_q, busy});
      OFS_HLO:  cfg_rdata = haddr_q[7:0];
      OFS_HHI:  cfg_rdata = 8'(haddr_q[HA_W-1:8]);
      OFS_XLO:  cfg_rdata = xaddr_q[7:0];
      OFS_XMID: cfg_rdata = xaddr_q[15:8];
      OFS_XHI:  cfg_rdata = 8'(xaddr_q[XA_W-1:16]);
      OFS_CNT:  cfg_rdata = 8'(cnt);
      default:  cfg_rdata = 8'h00;
    endcase
  end

  assign dir   = dir_q;
  assign inc   = inc_q;
  assign code  = code_q;
  assign haddr = haddr_q;
  assign xaddr = xaddr_q;

  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !step && cfg_sel && cfg_we && cfg_addr == OFS_HLO |=> $stable(haddr_q)); // R10
  AST_FIXED_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    step && !inc_q |=> haddr_q == $past(haddr_q)); // R7
  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R4
endmodule

// File: rtl/xm_seq.sv
module xm_seq
  import xm_pkg::*;
#(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] start_code,
  input  logic [CODE_W-1:0] code,
  input  logic              bus_gnt,
  output logic              busy,
  output logic              strobe,
  output logic [CNT_W-1:0]  cnt
);
  xm_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign busy   = (state_q == ST_XFER);
  assign strobe = busy & bus_gnt;
  assign cnt    = cnt_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_XFER;
          cnt_d   = CNT_W'(1) << start_code;
        end else begin
          cnt_d   = CNT_W'(1) << code;
        end
      end
      ST_XFER: begin
        if (strobe) begin
          if (cnt_q == CNT_W'(1)) begin
            state_d = ST_IDLE;
            cnt_d   = CNT_W'(1) << code;
          end else begin
            cnt_d   = cnt_q - CNT_W'(1);
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= CNT_W'(1);
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_DROP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(strobe) && $past(cnt_q) == CNT_W'(1)); // R8
  AST_COUNT_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cnt_q == (CNT_W'(1) << code)); // R9
  AST_HOLD_WITHOUT_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bus_gnt |=> cnt_q == $past(cnt_q)); // R4
endmodule

// File: rtl/xram_mover.sv
module xram_mover
  import xm_pkg::*;
#(
  parameter int HA_W   = 16,
  parameter int XA_W   = 19,
  parameter int CODE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_sel,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic [HA_W-1:0]  hst_addr,
  output logic             hst_en,
  output logic             hst_we,
  output logic [7:0]       hst_wdata,
  input  logic [7:0]       hst_rdata,
  output logic [XA_W-1:0]  xr_addr,
  output logic             xr_en,
  output logic             xr_we,
  output logic [7:0]       xr_wdata,
  input  logic [7:0]       xr_rdata
);
  localparam int CNT_W = 1 << CODE_W;

  logic              busy, strobe, start, dir, inc;
  logic [CODE_W-1:0] code, start_code;
  logic [CNT_W-1:0]  cnt;

  xm_regs #(.HA_W(HA_W), .XA_W(XA_W), .CODE_W(CODE_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .busy(busy), .step(strobe), .cnt(cnt), .dir(dir), .inc(inc), .code(code),
    .haddr(hst_addr), .xaddr(xr_addr), .start(start), .start_code(start_code)
  );

  xm_seq #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_code(start_code),
    .code(code), .bus_gnt(bus_gnt), .busy(busy), .strobe(strobe), .cnt(cnt)
  );

  assign bus_req   = busy;
  assign hst_en    = strobe;
  assign xr_en     = strobe;
  assign hst_we    = strobe & dir;
  assign xr_we     = strobe & ~dir;
  assign hst_wdata = xr_rdata;
  assign xr_wdata  = hst_rdata;

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(hst_we && xr_we)); // R3
  AST_XADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    xr_en |=> xr_addr == $past(xr_addr) + XA_W'(1)); // R6
endmodule

// File: tb/sim_xram_mover.sv
module sim_xram_mover;
  localparam int CLK_NS = 10;

  typedef struct packed {
    logic        side;
    logic [18:0] addr;
    logic [7:0]  data;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_sel, cfg_we;
  logic [2:0]  cfg_addr;
  logic [7:0]  cfg_wdata, cfg_rdata;
  logic        bus_req, bus_gnt;
  logic [15:0] hst_addr;
  logic        hst_en, hst_we;
  logic [7:0]  hst_wdata, hst_rdata;
  logic [18:0] xr_addr;
  logic        xr_en, xr_we;
  logic [7:0]  xr_wdata, xr_rdata;

  xram_mover u0 (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .hst_addr(hst_addr),
    .hst_en(hst_en), .hst_we(hst_we), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata), .xr_addr(xr_addr), .xr_en(xr_en), .xr_we(xr_we),
    .xr_wdata(xr_wdata), .xr_rdata(xr_rdata)
  );

  always #(CLK_NS/2) clk = ~clk;

  logic [7:0] hmem [1024];
  logic [7:0] xmem [1024];
  assign hst_rdata = hmem[hst_addr[9:0]];
  assign xr_rdata  = xmem[xr_addr[9:0]];
  always @(posedge clk) begin
    if (hst_en && hst_we) hmem[hst_addr[9:0]] <= hst_wdata;
    if (xr_en && xr_we)   xmem[xr_addr[9:0]]  <= xr_wdata;
  end

  item_t       exp_q[$];
  int          checks = 0;
  int          errors = 0;
  logic [15:0] m_h;
  logic [18:0] m_x;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: pops the scoreboard on every destination write
  always begin
    @(negedge clk);
    #1;
    if (hst_en && !bus_gnt) check(1'b0, "R4", "access without grant", 1, 0);
    if (hst_en != xr_en) check(1'b0, "R7", "host access missing", hst_en, xr_en);
    if ((hst_en && hst_we) || (xr_en && xr_we)) begin
      item_t got;
      got.side = hst_we;
      got.addr = hst_we ? {3'b000, hst_addr} : xr_addr;
      got.data = hst_we ? hst_wdata : xr_wdata;
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "unexpected byte", got, 0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        check(got == e, "R5", "byte side/addr/data", got, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_sel = 1'b1; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_sel = 1'b0; cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic set_addr(input logic [15:0] h, input logic [18:0] x);
    wr(3'd1, h[7:0]);  wr(3'd2, h[15:8]);
    wr(3'd3, x[7:0]);  wr(3'd4, x[15:8]); wr(3'd5, {5'b0, x[18:16]});
    m_h = h; m_x = x;
  endtask

  task automatic run(input bit dir, input bit inc, input logic [2:0] code,
                     input int gdly, input bit poke, input string req);
    int          n;
    int          cyc;
    logic [7:0]  v;
    n = 1 << code;
    for (int i = 0; i < n; i++) begin
      logic [15:0] ha;
      logic [18:0] xa;
      item_t       it;
      ha = inc ? m_h + 16'(i) : m_h;
      xa = m_x + 19'(i);
      if (!dir) it = '{side: 1'b0, addr: xa, data: hmem[ha[9:0]]};
      else      it = '{side: 1'b1, addr: {3'b000, ha}, data: xmem[xa[9:0]]};
      exp_q.push_back(it);
    end
    wr(3'd0, {2'b00, code, inc, dir, 1'b1});
    #1 check(bus_req == 1'b1, "R4", "bus_req after go", bus_req, 1);
    rd(3'd0, v);
    check(v[0] == 1'b1, "R4", "busy bit", v[0], 1);
    if (poke) begin
      wr(3'd0, 8'h00);
      wr(3'd1, ~m_h[7:0]);
      rd(3'd0, v);
      check(v == {2'b00, code, inc, dir, 1'b1}, "R10", "ctrl after busy write", v,
            {2'b00, code, inc, dir, 1'b1});
      rd(3'd1, v);
      check(v == m_h[7:0], "R10", "host lo after busy write", v, m_h[7:0]);
    end
    repeat (gdly) @(negedge clk);
    @(negedge clk);
    bus_gnt = 1'b1;
    cyc = 0;
    #1;
    while (bus_req && cyc < 400) begin
      cyc++;
      @(negedge clk);
      #1;
    end
    bus_gnt = 1'b0;
    check(cyc == n, "R8", {req, " granted cycles"}, cyc, n);
    check(exp_q.size() == 0, "R5", "bytes left in scoreboard", exp_q.size(), 0);
    if (inc) m_h = m_h + 16'(n);
    m_x = m_x + 19'(n);
    rd(3'd1, v); check(v == m_h[7:0],  "R9", "host lo after chunk", v, m_h[7:0]);
    rd(3'd2, v); check(v == m_h[15:8], "R9", "host hi after chunk", v, m_h[15:8]);
    rd(3'd3, v); check(v == m_x[7:0],  "R6", "xram lo after chunk", v, m_x[7:0]);
    rd(3'd4, v); check(v == m_x[15:8], "R6", "xram mid after chunk", v, m_x[15:8]);
    rd(3'd5, v); check(v == {5'b0, m_x[18:16]}, "R6", "xram hi after chunk", v, m_x[18:16]);
    rd(3'd6, v); check(v == 8'(n), "R9", "count restored", v, n);
    rd(3'd0, v); check(v[0] == 1'b0, "R8", "busy cleared", v[0], 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    check(1'b0, "R8", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 1024; i++) begin
      hmem[i] = 8'(i * 7 + 3);
      xmem[i] = 8'(i * 13 + 101);
    end
    rst_n = 1'b0; cfg_sel = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    bus_gnt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1 check(bus_req == 1'b0, "R1", "bus_req at reset", bus_req, 0);
    rd(3'd0, v); check(v == 8'h00, "R1", "ctrl at reset", v, 0);
    rd(3'd2, v); check(v == 8'h00, "R1", "host hi at reset", v, 0);
    rd(3'd4, v); check(v == 8'h00, "R1", "xram mid at reset", v, 0);
    rd(3'd6, v); check(v == 8'h01, "R1", "count at reset", v, 1);
    // R2 window map
    wr(3'd5, 8'hFF); rd(3'd5, v); check(v == 8'h07, "R2", "xram hi width", v, 8'h07);
    wr(3'd6, 8'h55); rd(3'd6, v); check(v == 8'h01, "R2", "count read-only", v, 1);
    wr(3'd7, 8'hAA); rd(3'd7, v); check(v == 8'h00, "R2", "offset 7", v, 0);
    wr(3'd2, 8'hC3); rd(3'd2, v); check(v == 8'hC3, "R2", "host hi readback", v, 8'hC3);
    // R3 control fields without go
    wr(3'd0, 8'b0010_0110); rd(3'd0, v);
    check(v == 8'b0010_0110, "R3", "ctrl readback", v, 8'h26);
    rd(3'd6, v); check(v == 8'd16, "R3", "count follows code 4", v, 16);

    set_addr(16'h0100, 19'h00200);
    run(1'b0, 1'b1, 3'd3, 0, 1'b0, "R5 stash inc");
    run(1'b0, 1'b1, 3'd3, 0, 1'b0, "R9 chained");
    set_addr(16'h0300, 19'h00040);
    run(1'b1, 1'b1, 3'd2, 3, 1'b0, "R4 fetch delayed grant");
    set_addr(16'h9F23, 19'h00080);
    run(1'b1, 1'b0, 3'd2, 0, 1'b0, "R7 fetch fixed port");
    set_addr(16'h0050, 19'h00300);
    run(1'b0, 1'b0, 3'd1, 0, 1'b0, "R7 stash fixed port");
    set_addr(16'h0010, 19'h7FFFE);
    run(1'b0, 1'b1, 3'd2, 0, 1'b0, "R6 xram wrap");
    set_addr(16'h0200, 19'h00100);
    run(1'b1, 1'b1, 3'd0, 0, 1'b0, "R3 single byte");
    set_addr(16'h0180, 19'h00180);
    run(1'b0, 1'b1, 3'd4, 2, 1'b1, "R10 busy writes");
    set_addr(16'h0000, 19'h00000);
    run(1'b0, 1'b1, 3'd7, 0, 1'b0, "R3 largest chunk");
    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule